// File: doc/BRIEF.md
# Handshaked Host-to-RAM Word Loader

This block lets a slow host fill an on-chip memory one word at a time. The host writes a word into a holding register and, if it wants to, a target address into a second register. It then sets a load flag. The block stores the held word, clears the flag itself and, if built with the option, pulses a completion interrupt. Because every store is started by the flag and not by a change in the data, a run of equal words is stored word by word. Addressing is either automatic, through an internal pointer that starts at zero and steps after each store, or explicit, from the address register. A pointer-clear input returns the pointer to zero. The memory comes up holding computed default contents, so it can be read before any host load.

The load handshake works like a valid/ready pair. Pulsing `load_set_i` is the valid. A low `load_flag_o` is the ready. A pulse while the flag is high is ignored, so the host must wait for the flag to read low before it offers the next word. This back-pressure allows at most one word every two cycles. A one-cycle-latency read port gives the stored sequence back to the logic that uses it.

Top module: `word_loader`

## Requirements
- R1: After reset, `load_flag_o`, `done_irq_o`, `full_o` and `rd_valid_o` are 0, `ptr_o` is 0 and `rd_data_o` is 0. Reset does not change the memory contents.
- R2: A `load_set_i` pulse sampled while `load_flag_o` is 0 makes `load_flag_o` 1 at the next edge. A pulse sampled while the flag is 1 has no effect and causes no second store. Without a pulse, a low flag stays low.
- R3: While `load_flag_o` is 1, writes to the data register (`data_we_i`) and to the address register (`addr_we_i`) are ignored. The held word stays as it was and is used again by a later load that has no new data write.
- R4: In a cycle where `load_flag_o` is 1 and `ptr_clr_i` is 0, the held word is written to memory. At the next edge `load_flag_o` returns to 0, and `done_irq_o` is 1 for exactly that one cycle (when `IRQ_ENABLE` is 1). Consecutive equal words are each stored at their own address.
- R5: With `explicit_mode_i` = 0 the word goes to the address in `ptr_o`, and `ptr_o` then increases by one. With `explicit_mode_i` = 1 the word goes to the address register and `ptr_o` is unchanged.
- R6: A store in automatic mode at address DEPTH-1 wraps `ptr_o` to 0 and sets `full_o`. `full_o` stays 1 until `ptr_clr_i`.
- R7: `ptr_clr_i` sampled high sets `ptr_o` to 0 and `full_o` to 0 at the next edge. A pending load is held, with the flag still 1, for as long as `ptr_clr_i` is high. After that it is stored in automatic mode at address 0.
- R8: From power-up, word i of the memory holds `INIT_PATTERN ^ i`, with i zero-extended to DW bits.
- R9: `rd_en_i` sampled high gives `rd_valid_o` = 1 and `rd_data_o` = the word at `rd_addr_i` one cycle later. Without `rd_en_i`, `rd_valid_o` is 0 and `rd_data_o` holds its value.
- R10: A read of the same address that is being written in that cycle is dropped. The next cycle shows `rd_valid_o` = 0 and `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we_i | input | 1 | Write strobe for the data holding register |
| data_i | input | DW | Word for the data holding register |
| addr_we_i | input | 1 | Write strobe for the address register |
| addr_i | input | AW | Value for the address register |
| load_set_i | input | 1 | Host sets the load flag (valid) |
| explicit_mode_i | input | 1 | 1: store at the address register; 0: store at the pointer |
| ptr_clr_i | input | 1 | Return the pointer to zero and clear full |
| load_flag_o | output | 1 | Load flag; low means ready for the next word |
| done_irq_o | output | 1 | One-cycle pulse after each store |
| ptr_o | output | AW | Automatic write pointer |
| full_o | output | 1 | Sticky: the pointer has wrapped |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DW | Read data |

## Verification
The main function is tried with a run of identical words, which shows that stores follow the flag and not changes in the data, and with a load offered again while the flag is high together with a new data word, which shows that both the extra flag pulse and the register write are ignored. Explicit-mode stores show whether the pointer really stays put. A load pending under a held pointer-clear shows that the store is deferred and lands at address 0. A full 64-word auto fill shows the wrap and the sticky full bit. Reads of the address being written in that cycle, and of a different address in the same cycle, tell a dropped read apart from a normal one.

// File: rtl/word_loader_pkg.sv
package word_loader_pkg;

  typedef enum logic {
    ADDR_AUTO     = 1'b0,
    ADDR_EXPLICIT = 1'b1
  } addr_mode_e;

  localparam int DEF_DW    = 16;
  localparam int DEF_DEPTH = 64;

  // Default memory word at a given index
  function automatic logic [DEF_DW-1:0] default_word(input logic [DEF_DW-1:0] pattern,
                                                     input int unsigned idx);
    logic [DEF_DW-1:0] w;
    w = DEF_DW'(idx);
    return pattern ^ w;
  endfunction

endpackage

// File: rtl/wl_host_regs.sv
module wl_host_regs #(
  parameter int DW         = 16,
  parameter int AW         = 6,
  parameter bit IRQ_ENABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_in,
  input  logic          load_set,
  input  logic          hold,
  output logic [DW-1:0] data_q,
  output logic [AW-1:0] addr_q,
  output logic          flag_q,
  output logic          fire,
  output logic          irq
);

  // The store happens in the flag cycle unless the pointer clear holds it off
  assign fire = flag_q & ~hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (fire) begin
      flag_q <= 1'b0;
    end else if (!flag_q && load_set) begin
      flag_q <= 1'b1;
    end
  end

  // Holding registers are frozen while a load is pending
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      addr_q <= '0;
    end else if (!flag_q) begin
      if (data_we) data_q <= data_in;
      if (addr_we) addr_q <= addr_in;
    end
  end

  generate
    if (IRQ_ENABLE) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
      end
      assign irq = irq_q;
    end else begin : g_no_irq
      assign irq = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/wl_pointer.sv
module wl_pointer #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          full
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr  <= '0;
      full <= 1'b0;
    end else if (step) begin
      if (ptr == LAST) begin
        ptr  <= '0;
        full <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wl_ram.sv
module wl_ram
  import word_loader_pkg::*;
#(
  parameter int          DW           = 16,
  parameter int          DEPTH        = 64,
  parameter int          AW           = $clog2(DEPTH),
  parameter logic [15:0] INIT_PATTERN = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic          collide;
  logic          rd_take;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(default_word(DEF_DW'(INIT_PATTERN), i));
    end
  end

  assign collide = we && (rd_addr == waddr);
  assign rd_take = rd_en && !collide;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_take;
      if (rd_take) rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/word_loader.sv
module word_loader
  import word_loader_pkg::*;
#(
  parameter int          DW           = 16,
  parameter int          DEPTH        = 64,
  parameter bit          IRQ_ENABLE   = 1'b1,
  parameter logic [15:0] INIT_PATTERN = 16'hA5C3,
  localparam int         AW           = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          load_set_i,
  input  logic          explicit_mode_i,
  input  logic          ptr_clr_i,
  output logic          load_flag_o,
  output logic          done_irq_o,
  output logic [AW-1:0] ptr_o,
  output logic          full_o,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);

  addr_mode_e    mode;
  logic [DW-1:0] data_q;
  logic [AW-1:0] addr_q;
  logic          wr_fire;
  logic [AW-1:0] wr_addr;
  logic          ptr_step;

  assign mode = explicit_mode_i ? ADDR_EXPLICIT : ADDR_AUTO;

  wl_host_regs #(
    .DW(DW), .AW(AW), .IRQ_ENABLE(IRQ_ENABLE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_we  (data_we_i),
    .data_in  (data_i),
    .addr_we  (addr_we_i),
    .addr_in  (addr_i),
    .load_set (load_set_i),
    .hold     (ptr_clr_i),
    .data_q   (data_q),
    .addr_q   (addr_q),
    .flag_q   (load_flag_o),
    .fire     (wr_fire),
    .irq      (done_irq_o)
  );

  assign wr_addr  = (mode == ADDR_EXPLICIT) ? addr_q : ptr_o;
  assign ptr_step = wr_fire && (mode == ADDR_AUTO);

  wl_pointer #(
    .DEPTH(DEPTH), .AW(AW)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ptr_clr_i),
    .step  (ptr_step),
    .ptr   (ptr_o),
    .full  (full_o)
  );

  wl_ram #(
    .DW(DW), .DEPTH(DEPTH), .AW(AW), .INIT_PATTERN(INIT_PATTERN)
  ) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_fire),
    .waddr    (wr_addr),
    .wdata    (data_q),
    .rd_en    (rd_en_i),
    .rd_addr  (rd_addr_i),
    .rd_valid (rd_valid_o),
    .rd_data  (rd_data_o)
  );

endmodule

// File: rtl/wl_checker.sv
module wl_checker #(
  parameter int AW         = 6,
  parameter bit IRQ_ENABLE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_set_i,
  input logic          explicit_mode_i,
  input logic          ptr_clr_i,
  input logic          rd_en_i,
  input logic [AW-1:0] rd_addr_i,
  input logic          load_flag_o,
  input logic          done_irq_o,
  input logic [AW-1:0] ptr_o,
  input logic          full_o,
  input logic          rd_valid_o,
  input logic          wr_fire,
  input logic [AW-1:0] wr_addr
);

  a_r2_set_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_flag_o && load_set_i) |=> load_flag_o);

  a_r2_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_flag_o && !load_set_i) |=> !load_flag_o);

  a_r4_flag_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (load_flag_o && !ptr_clr_i) |=> !load_flag_o);

  a_r4_irq_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (load_flag_o && !ptr_clr_i) |=> (done_irq_o || !IRQ_ENABLE));

  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o);

  a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !explicit_mode_i) |=> (ptr_o == $past(ptr_o) + {{(AW-1){1'b0}}, 1'b1}));

  a_r5_explicit_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && explicit_mode_i) |=> $stable(ptr_o));

  a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !ptr_clr_i) |=> full_o);

  a_r7_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr_i |=> (ptr_o == '0) && !full_o);

  a_r7_load_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (load_flag_o && ptr_clr_i) |=> load_flag_o);

  a_r9_read_served: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !(wr_fire && rd_addr_i == wr_addr)) |=> rd_valid_o);

  a_r10_collision_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && wr_fire && rd_addr_i == wr_addr) |=> !rd_valid_o);

  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);

endmodule

bind word_loader wl_checker #(.AW(AW), .IRQ_ENABLE(IRQ_ENABLE)) u_wl_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .load_set_i      (load_set_i),
  .explicit_mode_i (explicit_mode_i),
  .ptr_clr_i       (ptr_clr_i),
  .rd_en_i         (rd_en_i),
  .rd_addr_i       (rd_addr_i),
  .load_flag_o     (load_flag_o),
  .done_irq_o      (done_irq_o),
  .ptr_o           (ptr_o),
  .full_o          (full_o),
  .rd_valid_o      (rd_valid_o),
  .wr_fire         (wr_fire),
  .wr_addr         (wr_addr)
);

// File: tb/word_loader_test.sv
module word_loader_test;

  localparam int          DW    = 16;
  localparam int          DEPTH = 64;
  localparam int          AW    = 6;
  localparam logic [15:0] PAT   = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          data_we_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          addr_we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          load_set_i = 1'b0;
  logic          explicit_mode_i = 1'b0;
  logic          ptr_clr_i = 1'b0;
  logic          load_flag_o, done_irq_o, full_o, rd_valid_o;
  logic [AW-1:0] ptr_o;
  logic          rd_en_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;

  word_loader #(.DW(DW), .DEPTH(DEPTH), .IRQ_ENABLE(1'b1), .INIT_PATTERN(PAT)) uut (
    .clk(clk), .rst_n(rst_n), .data_we_i(data_we_i), .data_i(data_i),
    .addr_we_i(addr_we_i), .addr_i(addr_i), .load_set_i(load_set_i),
    .explicit_mode_i(explicit_mode_i), .ptr_clr_i(ptr_clr_i),
    .load_flag_o(load_flag_o), .done_irq_o(done_irq_o), .ptr_o(ptr_o),
    .full_o(full_o), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int m_flag, m_irq, m_ptr, m_full, m_rdv, m_rdd, m_dreg, m_areg;
  int m_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = int'(PAT) ^ i;
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_flag = 0; m_irq = 0; m_ptr = 0; m_full = 0;
      m_rdv = 0; m_rdd = 0; m_dreg = 0; m_areg = 0;
    end else begin
      int wen;
      int wa;
      wen = (m_flag == 1 && !ptr_clr_i) ? 1 : 0;
      wa  = explicit_mode_i ? m_areg : m_ptr;
      if (rd_en_i && !(wen == 1 && int'(rd_addr_i) == wa)) begin
        m_rdv = 1;
        m_rdd = m_mem[int'(rd_addr_i)];
      end else begin
        m_rdv = 0;
      end
      if (wen == 1) m_mem[wa] = m_dreg;
      if (m_flag == 0 && data_we_i) m_dreg = int'(data_i);
      if (m_flag == 0 && addr_we_i) m_areg = int'(addr_i);
      m_irq = wen;
      if (ptr_clr_i) begin
        m_ptr = 0; m_full = 0;
      end else if (wen == 1 && !explicit_mode_i) begin
        if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_full = 1; end
        else m_ptr = m_ptr + 1;
      end
      if (wen == 1) m_flag = 0;
      else if (m_flag == 0 && load_set_i) m_flag = 1;
    end
    if (cycles > 150000 && !finished) begin
      chk(1'b0, "WATCHDOG", "cycles", cycles, 150000);
      wrap_up();
    end
  end

  // Compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(load_flag_o) == m_flag, "R2", "load_flag_o", int'(load_flag_o), m_flag);
      chk(int'(done_irq_o) == m_irq, "R4", "done_irq_o", int'(done_irq_o), m_irq);
      chk(int'(ptr_o) == m_ptr, "R5", "ptr_o", int'(ptr_o), m_ptr);
      chk(int'(full_o) == m_full, "R6", "full_o", int'(full_o), m_full);
      chk(int'(rd_valid_o) == m_rdv, "R9", "rd_valid_o", int'(rd_valid_o), m_rdv);
      chk(int'(rd_data_o) == m_rdd, "R9", "rd_data_o", int'(rd_data_o), m_rdd);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic read_word(input int a, input string tag, input int exp);
    rd_en_i = 1'b1;
    rd_addr_i = AW'(a);
    tick();
    rd_en_i = 1'b0;
    chk(rd_valid_o == 1'b1, tag, "read valid", int'(rd_valid_o), 1);
    chk(int'(rd_data_o) == exp, tag, "read data", int'(rd_data_o), exp);
  endtask

  // Full load cycle; an optional read is placed in the store cycle
  task automatic load_word(input bit wr_data, input int d, input bit expl, input int a,
                           input bit do_rd, input int ra);
    data_we_i = wr_data;
    data_i = DW'(d);
    addr_we_i = expl;
    addr_i = AW'(a);
    explicit_mode_i = expl;
    tick();
    data_we_i = 1'b0;
    addr_we_i = 1'b0;
    load_set_i = 1'b1;
    tick();
    load_set_i = 1'b0;
    chk(load_flag_o == 1'b1, "R2", "flag raised", int'(load_flag_o), 1);
    rd_en_i = do_rd;
    rd_addr_i = AW'(ra);
    tick();
    rd_en_i = 1'b0;
    chk(load_flag_o == 1'b0, "R4", "flag self-cleared", int'(load_flag_o), 0);
    chk(done_irq_o == 1'b1, "R4", "irq pulse", int'(done_irq_o), 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    chk(!load_flag_o && !done_irq_o && !full_o && !rd_valid_o, "R1", "status bits",
        int'({load_flag_o, done_irq_o, full_o, rd_valid_o}), 0);
    chk(ptr_o == '0 && rd_data_o == '0, "R1", "ptr/rd_data", int'(ptr_o), 0);

    // R8: power-up contents
    read_word(0, "R8", int'(PAT) ^ 0);
    read_word(5, "R8", int'(PAT) ^ 5);
    read_word(63, "R8", int'(PAT) ^ 63);

    // R4/R5: duplicate words each stored in auto mode
    load_word(1'b1, 16'h00FF, 1'b0, 0, 1'b0, 0);
    load_word(1'b1, 16'h00FF, 1'b0, 0, 1'b0, 0);
    tick();
    chk(done_irq_o == 1'b0, "R4", "irq one cycle", int'(done_irq_o), 0);
    load_word(1'b1, 16'h1234, 1'b0, 0, 1'b0, 0);
    read_word(0, "R4", 16'h00FF);
    read_word(1, "R4", 16'h00FF);
    read_word(2, "R5", 16'h1234);
    chk(ptr_o == 6'd3, "R5", "ptr after three", int'(ptr_o), 3);

    // R2/R3: second set and register writes while flag is high
    data_we_i = 1'b1; data_i = 16'h1111; explicit_mode_i = 1'b0;
    tick();
    data_we_i = 1'b0; load_set_i = 1'b1;
    tick();
    data_we_i = 1'b1; data_i = 16'h2222; addr_we_i = 1'b1; addr_i = 6'd50;
    tick();
    data_we_i = 1'b0; addr_we_i = 1'b0; load_set_i = 1'b0;
    tick();
    chk(load_flag_o == 1'b0, "R2", "set while high ignored", int'(load_flag_o), 0);
    chk(ptr_o == 6'd4, "R2", "single store", int'(ptr_o), 4);
    read_word(3, "R3", 16'h1111);
    load_word(1'b0, 0, 1'b0, 0, 1'b0, 0);
    read_word(4, "R3", 16'h1111);

    // R5: explicit addressing leaves the pointer alone
    load_word(1'b1, 16'h4040, 1'b1, 40, 1'b0, 0);
    chk(ptr_o == 6'd5, "R5", "explicit keeps ptr", int'(ptr_o), 5);
    read_word(40, "R5", 16'h4040);
    explicit_mode_i = 1'b0;

    // R7: load pending during pointer clear goes to address 0
    data_we_i = 1'b1; data_i = 16'h7070;
    tick();
    data_we_i = 1'b0; load_set_i = 1'b1;
    tick();
    load_set_i = 1'b0; ptr_clr_i = 1'b1;
    tick();
    tick();
    chk(load_flag_o == 1'b1, "R7", "load deferred", int'(load_flag_o), 1);
    chk(ptr_o == 6'd0, "R7", "ptr cleared", int'(ptr_o), 0);
    ptr_clr_i = 1'b0;
    tick();
    chk(load_flag_o == 1'b0 && ptr_o == 6'd1, "R7", "stored after clear", int'(ptr_o), 1);
    read_word(0, "R7", 16'h7070);

    // R6: fill the whole memory, wrap and sticky full
    ptr_clr_i = 1'b1;
    tick();
    ptr_clr_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) load_word(1'b1, 16'h0100 + i, 1'b0, 0, 1'b0, 0);
    chk(ptr_o == 6'd0, "R6", "ptr wrapped", int'(ptr_o), 0);
    chk(full_o == 1'b1, "R6", "full set", int'(full_o), 1);
    read_word(63, "R6", 16'h013F);
    load_word(1'b1, 16'hBEEF, 1'b0, 0, 1'b0, 0);
    chk(full_o == 1'b1 && ptr_o == 6'd1, "R6", "full sticky", int'(full_o), 1);
    ptr_clr_i = 1'b1;
    tick();
    ptr_clr_i = 1'b0;
    chk(full_o == 1'b0, "R7", "full cleared", int'(full_o), 0);

    // R10: read of the address written in the same cycle is dropped
    read_word(10, "R9", 16'h010A);
    load_word(1'b1, 16'h7777, 1'b1, 10, 1'b1, 10);
    chk(rd_valid_o == 1'b0, "R10", "colliding read dropped", int'(rd_valid_o), 0);
    chk(rd_data_o == 16'h010A, "R10", "rd_data held", int'(rd_data_o), 16'h010A);
    read_word(10, "R10", 16'h7777);
    // R9: a read of another address in a store cycle is served
    load_word(1'b1, 16'h5555, 1'b1, 11, 1'b1, 12);
    chk(rd_valid_o == 1'b1, "R9", "other-address read", int'(rd_valid_o), 1);
    chk(rd_data_o == 16'h010C, "R9", "other-address data", int'(rd_data_o), 16'h010C);
    tick();
    chk(rd_valid_o == 1'b0, "R9", "idle no valid", int'(rd_valid_o), 0);

    repeat (2) tick();
    wrap_up();
  end

endmodule